// File: doc/BRIEF.md
# Gated-Bus Instruction Fetch Sequencer

This block runs the instruction fetch phase of a small accumulator-style processor. It keeps four registers: an address latch that drives the external address lines, a buffer that catches data returned by memory, a program counter that points at the next instruction to fetch, and an instruction holding register. Every move between these registers goes over one internal bus. Each source that may drive the bus has its own output gate, and each destination has its own load gate. The sequencer opens exactly the gates that the current step needs.

A fetch takes four steps. In the first step the program counter goes over the bus into the address latch. In the second step the read strobe is raised and, in the same cycle, the counter steps by one. In the third step the word that memory returns is caught in the buffer. In the fourth step the buffer goes over the bus into the instruction register. The block then flags the new instruction for one cycle. It waits in an execute placeholder until the execute side reports completion, and then begins the next fetch. Memory is synchronous with a fixed read latency of one cycle.

Top module: `fetch_xfer_ctrl`

## Requirements
- R1: While reset is high and in the first cycle after it falls, the program counter reads 0, the read strobe is low and the ready flag is low. The first read strobe appears in the second cycle after reset falls, with address 0.
- R2: Each fetch raises the read strobe for exactly one cycle. During that cycle the address output equals the program counter value of that fetch.
- R3: The program counter increases by 1 in the read cycle and is visible one cycle later. It wraps from 2^ADDR_W-1 to 0, and at all other times it holds its value.
- R4: The buffer captures the data input only in the cycle that follows the read strobe. Data present on the input in any other cycle has no effect on the fetched instruction.
- R5: The instruction register loads from the buffer in the cycle after capture. The ready flag is high for exactly the next cycle, and during that cycle the instruction output carries the word read from the fetch address.
- R6: After the ready cycle the sequencer waits until the done input is high. The next read strobe comes exactly two cycles after the cycle in which done is seen. A done input that is high in the ready cycle or during the fetch steps is ignored.
- R7: At most one source gate drives the internal bus in any cycle. The address latch receives the program counter over the bus, and the instruction register receives the buffer over the bus.
- R8: The instruction output holds its value from one instruction-register load to the next, including through the whole execute wait.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous reset, active high |
| mem_addr_o | output | ADDR_W | Address to memory, driven from the address latch |
| mem_rd_o | output | 1 | Read strobe to memory |
| mem_rdata_i | input | DATA_W | Read data from memory, valid one cycle after the strobe |
| exec_done_i | input | 1 | Execute phase finished; sampled only during the execute wait |
| instr_valid_o | output | 1 | One-cycle flag marking a newly loaded instruction |
| instr_o | output | DATA_W | Contents of the instruction register |
| pc_o | output | ADDR_W | Contents of the program counter |

## Verification
The counter increment and the memory read share one cycle. The bench therefore samples the address output in the strobe cycle and expects the old counter value there. In the following cycle it expects the counter to be one higher. This is swept over every address of an 8-bit space, including the wrap to 0. The completion input can also coincide with the ready flag. The bench holds done high through the instruction-load and ready cycles and drops it in the first execute cycle. Any early hand-off would then show up as a read strobe during the wait, and the bench treats that as a failure. The memory model returns a distinct junk word in every cycle without a strobe, so a capture made one cycle off would deliver a wrong instruction.

// File: rtl/fxc_pkg.sv
package fxc_pkg;

    // Bus source indices (order used by the gated bus and the checker)
    localparam int SRC_PC  = 0;
    localparam int SRC_MBR = 1;
    localparam int N_SRC   = 2;

    typedef enum logic [2:0] {
        ST_ADDR  = 3'd0,   // counter -> address latch over the bus
        ST_READ  = 3'd1,   // strobe memory, counter + 1
        ST_CAPT  = 3'd2,   // memory data -> buffer
        ST_IRLD  = 3'd3,   // buffer -> instruction register over the bus
        ST_RDY   = 3'd4,   // flag new instruction
        ST_EXEC  = 3'd5    // execute placeholder, wait for done
    } fetch_state_e;

    typedef struct packed {
        logic [N_SRC-1:0] src_gate;  // one bit per bus source
        logic             mar_in;
        logic             ir_in;
        logic             mem_rd;
        logic             pc_inc;
        logic             mbr_cap;
        logic             instr_valid;
    } xfer_ctl_t;

endpackage

// File: rtl/fxc_sequencer.sv
module fxc_sequencer
    import fxc_pkg::*;
(
    input  logic      clk,
    input  logic      rst,
    input  logic      exec_done_i,
    output xfer_ctl_t ctl_o
);

    typedef struct packed {
        fetch_state_e state;
    } seq_regs_t;

    seq_regs_t r_d, r_q;
    xfer_ctl_t ctl;

    always_comb begin
        r_d = r_q;
        ctl = '0;
        unique case (r_q.state)
            ST_ADDR: begin
                ctl.src_gate[SRC_PC] = 1'b1;
                ctl.mar_in           = 1'b1;
                r_d.state            = ST_READ;
            end
            ST_READ: begin
                ctl.mem_rd = 1'b1;
                ctl.pc_inc = 1'b1;
                r_d.state  = ST_CAPT;
            end
            ST_CAPT: begin
                ctl.mbr_cap = 1'b1;
                r_d.state   = ST_IRLD;
            end
            ST_IRLD: begin
                ctl.src_gate[SRC_MBR] = 1'b1;
                ctl.ir_in             = 1'b1;
                r_d.state             = ST_RDY;
            end
            ST_RDY: begin
                ctl.instr_valid = 1'b1;
                r_d.state       = ST_EXEC;
            end
            ST_EXEC: begin
                if (exec_done_i) begin
                    r_d.state = ST_ADDR;
                end
            end
            default: begin
                r_d.state = ST_ADDR;
            end
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            r_q.state <= ST_ADDR;
        end else begin
            r_q <= r_d;
        end
    end

    assign ctl_o = ctl;

endmodule

// File: rtl/fxc_gated_bus.sv
module fxc_gated_bus #(
    parameter int N_SRC = 2,
    parameter int W     = 16
) (
    input  logic [N_SRC-1:0]        gate_i,
    input  logic [N_SRC-1:0][W-1:0] src_i,
    output logic [W-1:0]            bus_o
);

    logic [N_SRC:0][W-1:0] acc;

    assign acc[0] = '0;

    for (genvar g = 0; g < N_SRC; g++) begin : g_src
        assign acc[g+1] = acc[g] | (src_i[g] & {W{gate_i[g]}});
    end

    assign bus_o = acc[N_SRC];

endmodule

// File: rtl/fxc_regs.sv
module fxc_regs
    import fxc_pkg::*;
#(
    parameter int ADDR_W = 8,
    parameter int DATA_W = 16
) (
    input  logic              clk,
    input  logic              rst,
    input  xfer_ctl_t         ctl_i,
    input  logic [DATA_W-1:0] bus_i,
    input  logic [DATA_W-1:0] mem_rdata_i,
    output logic [ADDR_W-1:0] mar_o,
    output logic [DATA_W-1:0] mbr_o,
    output logic [ADDR_W-1:0] pc_o,
    output logic [DATA_W-1:0] ir_o
);

    typedef struct packed {
        logic [ADDR_W-1:0] mar;
        logic [DATA_W-1:0] mbr;
        logic [ADDR_W-1:0] pc;
        logic [DATA_W-1:0] ir;
    } dp_regs_t;

    dp_regs_t r_d, r_q;

    always_comb begin
        r_d = r_q;
        if (ctl_i.mar_in) begin
            r_d.mar = bus_i[ADDR_W-1:0];
        end
        if (ctl_i.pc_inc) begin
            r_d.pc = r_q.pc + 1'b1;
        end
        if (ctl_i.mbr_cap) begin
            r_d.mbr = mem_rdata_i;
        end
        if (ctl_i.ir_in) begin
            r_d.ir = bus_i;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            r_q <= '0;
        end else begin
            r_q <= r_d;
        end
    end

    assign mar_o = r_q.mar;
    assign mbr_o = r_q.mbr;
    assign pc_o  = r_q.pc;
    assign ir_o  = r_q.ir;

endmodule

// File: rtl/fetch_xfer_ctrl.sv
module fetch_xfer_ctrl
    import fxc_pkg::*;
#(
    parameter int ADDR_W = 8,
    parameter int DATA_W = 16
) (
    input  logic              clk,
    input  logic              rst,
    output logic [ADDR_W-1:0] mem_addr_o,
    output logic              mem_rd_o,
    input  logic [DATA_W-1:0] mem_rdata_i,
    input  logic              exec_done_i,
    output logic              instr_valid_o,
    output logic [DATA_W-1:0] instr_o,
    output logic [ADDR_W-1:0] pc_o
);

    xfer_ctl_t                     ctl;
    logic [N_SRC-1:0]              gate_src;
    logic [N_SRC-1:0][DATA_W-1:0]  bus_src;
    logic [DATA_W-1:0]             ibus;
    logic [ADDR_W-1:0]             mar;
    logic [DATA_W-1:0]             mbr;
    logic [ADDR_W-1:0]             pc;
    logic [DATA_W-1:0]             ir;

    fxc_sequencer u_seq (
        .clk         (clk),
        .rst         (rst),
        .exec_done_i (exec_done_i),
        .ctl_o       (ctl)
    );

    assign gate_src          = ctl.src_gate;
    assign bus_src[SRC_PC]   = DATA_W'(pc);
    assign bus_src[SRC_MBR]  = mbr;

    fxc_gated_bus #(
        .N_SRC (N_SRC),
        .W     (DATA_W)
    ) u_bus (
        .gate_i (gate_src),
        .src_i  (bus_src),
        .bus_o  (ibus)
    );

    fxc_regs #(
        .ADDR_W (ADDR_W),
        .DATA_W (DATA_W)
    ) u_regs (
        .clk         (clk),
        .rst         (rst),
        .ctl_i       (ctl),
        .bus_i       (ibus),
        .mem_rdata_i (mem_rdata_i),
        .mar_o       (mar),
        .mbr_o       (mbr),
        .pc_o        (pc),
        .ir_o        (ir)
    );

    assign mem_addr_o    = mar;
    assign mem_rd_o      = ctl.mem_rd;
    assign instr_valid_o = ctl.instr_valid;
    assign instr_o       = ir;
    assign pc_o          = pc;

endmodule

// File: rtl/fxc_checker.sv
module fxc_checker #(
    parameter int ADDR_W = 8,
    parameter int DATA_W = 16
) (
    input logic              clk,
    input logic              rst,
    input logic [1:0]        gate_src,
    input logic              ir_load,
    input logic              mem_rd,
    input logic [ADDR_W-1:0] mem_addr,
    input logic [ADDR_W-1:0] pc,
    input logic [DATA_W-1:0] instr,
    input logic              instr_valid
);

    AST_ONE_BUS_SRC: assert property (@(posedge clk) disable iff (rst)
        $onehot0(gate_src)); // R7

    AST_RD_PULSE: assert property (@(posedge clk) disable iff (rst)
        mem_rd |=> !mem_rd); // R2

    AST_RD_ADDR: assert property (@(posedge clk) disable iff (rst)
        mem_rd |-> (mem_addr == pc)); // R2

    AST_PC_STEP: assert property (@(posedge clk) disable iff (rst)
        mem_rd |=> (pc == ADDR_W'($past(pc) + 1'b1))); // R3

    AST_PC_HOLD: assert property (@(posedge clk) disable iff (rst)
        !mem_rd |=> $stable(pc)); // R3

    AST_VALID_PULSE: assert property (@(posedge clk) disable iff (rst)
        instr_valid |=> !instr_valid); // R5

    AST_NO_RD_WITH_VALID: assert property (@(posedge clk) disable iff (rst)
        !(instr_valid && mem_rd)); // R6

    AST_IR_HOLD: assert property (@(posedge clk) disable iff (rst)
        !ir_load |=> $stable(instr)); // R8

endmodule

bind fetch_xfer_ctrl fxc_checker #(
    .ADDR_W (ADDR_W),
    .DATA_W (DATA_W)
) u_chk (
    .clk         (clk),
    .rst         (rst),
    .gate_src    (gate_src),
    .ir_load     (ctl.ir_in),
    .mem_rd      (mem_rd_o),
    .mem_addr    (mem_addr_o),
    .pc          (pc_o),
    .instr       (instr_o),
    .instr_valid (instr_valid_o)
);

// File: tb/fetch_xfer_ctrl_tb.sv
module fetch_xfer_ctrl_tb;

    localparam int CLK_PERIOD = 10;
    localparam int ADDR_W     = 8;
    localparam int DATA_W     = 16;
    localparam int N_INSTR    = 262;

    logic              clk = 1'b0;
    logic              rst = 1'b1;
    logic [ADDR_W-1:0] mem_addr;
    logic              mem_rd;
    logic [DATA_W-1:0] mem_rdata = '0;
    logic              exec_done = 1'b0;
    logic              instr_valid;
    logic [DATA_W-1:0] instr;
    logic [ADDR_W-1:0] pc;

    int n_chk  = 0;
    int n_fail = 0;
    bit done   = 1'b0;

    always #(CLK_PERIOD/2) clk = ~clk;

    fetch_xfer_ctrl #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_dut (
        .clk           (clk),
        .rst           (rst),
        .mem_addr_o    (mem_addr),
        .mem_rd_o      (mem_rd),
        .mem_rdata_i   (mem_rdata),
        .exec_done_i   (exec_done),
        .instr_valid_o (instr_valid),
        .instr_o       (instr),
        .pc_o          (pc)
    );

    function automatic logic [DATA_W-1:0] word_at(input logic [ADDR_W-1:0] a);
        word_at = DATA_W'((int'(a) * 40503 + 4660) & 16'hFFFF);
    endfunction

    // Synchronous memory, one-cycle latency; junk whenever no strobe
    always @(posedge clk) begin
        if (mem_rd) mem_rdata <= word_at(mem_addr);
        else        mem_rdata <= ~word_at(mem_addr) ^ 16'h5A5A;
    end

    task automatic chk(input bit ok, input string req, input string what,
                       input longint act, input longint exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
        end
    endtask

    // Entered at a negedge in the address step; leaves at the next one.
    task automatic fetch_one(input logic [ADDR_W-1:0] epc, input int dly,
                             input bit early);
        logic [DATA_W-1:0] ew;
        ew = word_at(epc);
        chk(mem_rd == 1'b0, "R2", "strobe low in address step", mem_rd, 0);
        @(negedge clk); // read step
        chk(mem_rd == 1'b1, "R2", "strobe in read step", mem_rd, 1);
        chk(mem_addr == epc, "R7", "address latch from counter", mem_addr, epc);
        chk(pc == epc, "R3", "counter before step", pc, epc);
        @(negedge clk); // capture step
        chk(mem_rd == 1'b0, "R2", "strobe one cycle", mem_rd, 0);
        chk(pc == ADDR_W'(epc + 1), "R3", "counter stepped", pc, ADDR_W'(epc + 1));
        @(negedge clk); // instruction load step
        chk(instr_valid == 1'b0, "R5", "flag low in load step", instr_valid, 0);
        if (early) exec_done = 1'b1;
        @(negedge clk); // ready step
        chk(instr_valid == 1'b1, "R5", "ready flag", instr_valid, 1);
        chk(instr == ew, "R4", "fetched word", instr, ew);
        @(negedge clk); // first execute cycle
        exec_done = 1'b0;
        chk(instr_valid == 1'b0, "R5", "flag one cycle", instr_valid, 0);
        for (int k = 0; k < dly; k++) begin
            chk(mem_rd == 1'b0, "R6", "no fetch while waiting", mem_rd, 0);
            chk(instr == ew, "R8", "instruction held", instr, ew);
            @(negedge clk);
        end
        exec_done = 1'b1;
        @(negedge clk); // address step of next fetch
        exec_done = 1'b0;
        chk(mem_rd == 1'b0 && instr_valid == 1'b0, "R6", "address step after done",
            {mem_rd, instr_valid}, 0);
        chk(instr == ew, "R8", "instruction held into next fetch", instr, ew);
    endtask

    initial begin
        logic [ADDR_W-1:0] epc;
        repeat (3) @(negedge clk);
        chk(pc == '0, "R1", "counter in reset", pc, 0);
        chk(mem_rd == 1'b0 && instr_valid == 1'b0, "R1", "outputs in reset",
            {mem_rd, instr_valid}, 0);
        rst = 1'b0;
        chk(pc == '0 && mem_rd == 1'b0, "R1", "first cycle after reset", {pc, mem_rd}, 0);
        @(negedge clk);
        chk(mem_rd == 1'b1 && mem_addr == '0, "R1", "first read at address 0",
            {mem_rd, mem_addr}, 9'h100);
        chk(pc == '0, "R3", "counter held before read", pc, 0);
        // back up: restart cleanly from reset for the sweep
        rst = 1'b1;
        @(negedge clk);
        rst = 1'b0;
        epc = '0;
        for (int i = 0; i < N_INSTR; i++) begin
            int d;
            bit e;
            d = i % 4;
            e = (d > 0) && (i % 3 == 0);
            fetch_one(epc, d, e);
            epc = ADDR_W'(epc + 1);
        end
        chk(pc == ADDR_W'(N_INSTR), "R3", "counter after wrap", pc, ADDR_W'(N_INSTR));
        done = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            n_chk++;
            n_fail++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
            $finish;
        end
    end

endmodule